// File: doc/BRIEF.md
# Multiply-Accumulate Side Unit

A 32x32 unsigned multiplier with a 64-bit accumulator that sits beside a processor core. The core presents two operand registers to the unit continuously. It reaches a small window of three 32-bit words through a byte-granular transfer port: a control/status word, the low product word and the high product word.

The unit has two modes, chosen by one bit of the control word. In multiply-only mode the operands are captured on every clock and the product words follow them one cycle later, while the accumulator is kept at zero. In accumulate mode nothing moves until the core writes the control word. Each such write captures the operands once, adds their product into the accumulator and shows the sum in the product words. A sticky carry flag records a wrap of the 64-bit sum. Writing the flag position with 1 clears the flag and empties the accumulator.

A transfer names a start register, a start byte and a byte count. Bytes walk upward through the lanes of a word and then roll over into the next word. A transfer that would run past the end of the window is refused.

Top module: `mac_side_unit`

## Requirements
- R1: After reset the control word reads 0 (multiply-only mode, carry clear). `rdValid` and `xferErr` are low, and they stay low in any cycle that follows a cycle without a transfer request.
- R2: In multiply-only mode (control bit 0 = 0) the product words are loaded on every clock edge with `opA*opB` as presented before that edge. A read returns the product registered at the edge before the read's own edge.
- R3: In multiply-only mode the accumulator is held at zero. The first accumulate after entering accumulate mode therefore yields just `opA*opB`.
- R4: In accumulate mode (control bit 0 = 1) the product words hold while the operands change. A write that touches byte lane 0 of the control word, with bit 0 = 1 and bit 1 = 0, captures the operands and loads accumulator and product words with accumulator + `opA*opB`.
- R5: When that 64-bit sum wraps, the carry flag (control bit 1) is set. It stays set through later accumulations until it is cleared.
- R6: A control-word write with bit 1 = 1 clears the carry flag and zeroes the accumulator. It performs no accumulation, and the product words keep their value in accumulate mode.
- R7: A transfer covers window bytes start..start+len-1, where start = 4*register + byte. Window byte k is bits [8k+7:8k], with word 0 = control, word 1 = product low and word 2 = product high. A read raises `rdValid` one cycle later, with the covered bytes on `rdData` and all other bytes zero. A length of 0 reads all zeros.
- R8: A transfer with start+len > 12 is refused. `xferErr` pulses one cycle later, `rdValid` stays low, and no state changes.
- R9: A write that does not cover byte lane 0 of the control word has no effect, and so does any write to the product words. Control bits 31..2 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 32 | First operand register value |
| opB | input | 32 | Second operand register value |
| xferEn | input | 1 | Transfer request this cycle |
| xferWrite | input | 1 | 1 = write into the window, 0 = read |
| xferReg | input | 3 | Start register within the window |
| xferByte | input | 2 | Start byte lane within that register |
| xferLen | input | 4 | Number of bytes to transfer |
| xferWData | input | 96 | Write data laid out as the window image |
| rdValid | output | 1 | Read data valid (one cycle after the request) |
| rdData | output | 96 | Read data as window image, uncovered bytes zero |
| xferErr | output | 1 | Pulse: the previous transfer was refused |

## Verification
The hardest state to reach from the ports is a wrapped accumulator with the carry flag set. It is then followed by an accumulation that must leave the flag set. The bench gets there by entering accumulate mode, clearing the accumulator, and driving all-ones operands through two successive control-word writes. The second write pushes the sum past 2^64, and the expected sum is computed in the bench with 65-bit arithmetic. A refused write that would have cleared the flag is also driven, to show the state survives it.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  localparam int DATA_W    = 32;
  localparam int PROD_W    = 2 * DATA_W;
  localparam int LANES     = DATA_W / 8;
  localparam int WIN_REGS  = 3;
  localparam int WIN_BYTES = WIN_REGS * LANES;
  localparam int WIN_W     = WIN_BYTES * 8;
  localparam int REG_W     = 3;
  localparam int BYTE_W    = $clog2(LANES);
  localparam int LEN_W     = 4;
  localparam int IDX_W     = REG_W + BYTE_W + 2;
  localparam int MODE_BIT  = 0;
  localparam int CARRY_BIT = 1;

  typedef struct packed {
    logic                 modeWr;
    logic                 modeVal;
    logic                 clrReq;
    logic                 rdReq;
    logic                 errReq;
    logic [WIN_BYTES-1:0] laneSel;
  } macStrobe_t;
endpackage

// File: rtl/mac_ctrl.sv
`timescale 1ns/1ps
module mac_ctrl
  import mac_pkg::*;
(
  input  logic              xferEn,
  input  logic              xferWrite,
  input  logic [REG_W-1:0]  xferReg,
  input  logic [BYTE_W-1:0] xferByte,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [WIN_W-1:0]  xferWData,
  output macStrobe_t        strb
);
  logic [IDX_W-1:0]     startIdx;
  logic [IDX_W-1:0]     endIdx;
  logic                 inRange;
  logic [WIN_BYTES-1:0] laneHit;
  logic                 unusedWData;

  assign startIdx = IDX_W'(xferReg) * IDX_W'(LANES) + IDX_W'(xferByte);
  assign endIdx   = startIdx + IDX_W'(xferLen);
  assign inRange  = endIdx <= IDX_W'(WIN_BYTES);

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_lane
    assign laneHit[b] = (IDX_W'(b) >= startIdx) && (IDX_W'(b) < endIdx);
  end

  // only the two low bits of the control word are storable
  assign unusedWData = ^{xferWData[WIN_W-1:CARRY_BIT+1]};

  always_comb begin
    strb         = '0;
    strb.laneSel = laneHit;
    strb.modeWr  = xferEn && xferWrite && inRange && laneHit[0];
    strb.modeVal = xferWData[MODE_BIT];
    strb.clrReq  = xferWData[CARRY_BIT];
    strb.rdReq   = xferEn && !xferWrite && inRange;
    strb.errReq  = xferEn && !inRange;
  end
endmodule

// File: rtl/mac_datapath.sv
`timescale 1ns/1ps
module mac_datapath
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  macStrobe_t        strb,
  output logic              rdValid,
  output logic [WIN_W-1:0]  rdData,
  output logic              xferErr
);
  logic              modeQ;
  logic              carryQ;
  logic [PROD_W-1:0] accQ;
  logic [PROD_W-1:0] prodQ;
  logic [PROD_W-1:0] mulRes;
  logic [PROD_W:0]   sumRes;
  logic              nextMode;
  logic [WIN_W-1:0]  winImg;
  logic [WIN_W-1:0]  rdNext;

  assign mulRes   = PROD_W'(opA) * PROD_W'(opB);
  assign sumRes   = {1'b0, accQ} + {1'b0, mulRes};
  assign nextMode = strb.modeWr ? strb.modeVal : modeQ;
  assign winImg   = {prodQ, {(DATA_W-2){1'b0}}, carryQ, modeQ};

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_rdLane
    assign rdNext[8*b +: 8] = (strb.rdReq && strb.laneSel[b]) ? winImg[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      carryQ  <= 1'b0;
      accQ    <= '0;
      prodQ   <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
      xferErr <= 1'b0;
    end else begin
      if (strb.modeWr) modeQ <= strb.modeVal;
      if (!nextMode) begin
        prodQ <= mulRes;
        accQ  <= '0;
        if (strb.modeWr && strb.clrReq) carryQ <= 1'b0;
      end else if (strb.modeWr) begin
        if (strb.clrReq) begin
          accQ   <= '0;
          carryQ <= 1'b0;
        end else begin
          prodQ <= sumRes[PROD_W-1:0];
          accQ  <= sumRes[PROD_W-1:0];
          if (sumRes[PROD_W]) carryQ <= 1'b1;
        end
      end
      rdValid <= strb.rdReq;
      rdData  <= rdNext;
      xferErr <= strb.errReq;
    end
  end
endmodule

// File: rtl/mac_side_unit.sv
`timescale 1ns/1ps
module mac_side_unit
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              xferEn,
  input  logic              xferWrite,
  input  logic [REG_W-1:0]  xferReg,
  input  logic [BYTE_W-1:0] xferByte,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [WIN_W-1:0]  xferWData,
  output logic              rdValid,
  output logic [WIN_W-1:0]  rdData,
  output logic              xferErr
);
  macStrobe_t strb;

  mac_ctrl u_ctrl (
    .xferEn(xferEn), .xferWrite(xferWrite), .xferReg(xferReg),
    .xferByte(xferByte), .xferLen(xferLen), .xferWData(xferWData),
    .strb(strb)
  );

  mac_datapath u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .strb(strb),
    .rdValid(rdValid), .rdData(rdData), .xferErr(xferErr)
  );
endmodule

// File: rtl/mac_side_unit_chk.sv
`timescale 1ns/1ps
module mac_side_unit_chk
  import mac_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              xferEn,
  input logic              xferWrite,
  input logic [REG_W-1:0]  xferReg,
  input logic [BYTE_W-1:0] xferByte,
  input logic [LEN_W-1:0]  xferLen,
  input logic              rdValid,
  input logic [WIN_W-1:0]  rdData,
  input logic              xferErr
);
  logic [IDX_W-1:0] reqEnd;
  logic             reqFits;
  assign reqEnd  = IDX_W'(xferReg) * IDX_W'(LANES) + IDX_W'(xferByte) + IDX_W'(xferLen);
  assign reqFits = reqEnd <= IDX_W'(WIN_BYTES);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !xferEn |=> (!rdValid && !xferErr));

  p_read_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xferEn && !xferWrite && reqFits) |=> (rdValid && !xferErr));

  p_idle_data_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  p_refuse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (xferEn && !reqFits) |=> (xferErr && !rdValid && rdData == '0));

  p_write_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    (xferEn && xferWrite && reqFits) |=> (!rdValid && !xferErr));
endmodule

bind mac_side_unit mac_side_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .xferEn(xferEn), .xferWrite(xferWrite),
  .xferReg(xferReg), .xferByte(xferByte), .xferLen(xferLen),
  .rdValid(rdValid), .rdData(rdData), .xferErr(xferErr)
);

// File: tb/mac_side_unit_bench.sv
`timescale 1ns/1ps
module mac_side_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        xferEn = 1'b0, xferWrite = 1'b0;
  logic [2:0]  xferReg = '0;
  logic [1:0]  xferByte = '0;
  logic [3:0]  xferLen = '0;
  logic [95:0] xferWData = '0;
  logic        rdValid, xferErr;
  logic [95:0] rdData;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mac_side_unit u_mac_side_unit (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .xferEn(xferEn),
    .xferWrite(xferWrite), .xferReg(xferReg), .xferByte(xferByte),
    .xferLen(xferLen), .xferWData(xferWData), .rdValid(rdValid),
    .rdData(rdData), .xferErr(xferErr)
  );

  function automatic logic [95:0] img(input logic mode, input logic carry, input logic [63:0] prod);
    return {prod, 30'h0, carry, mode};
  endfunction

  function automatic logic [95:0] laneMask(input int rg, input int by, input int ln);
    logic [95:0] m = '0;
    for (int k = 0; k < 12; k++)
      if (k >= rg*4+by && k < rg*4+by+ln) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input int rg, input int by, input int ln, input logic [95:0] wd);
    @(negedge clk);
    xferEn = 1'b1; xferWrite = wr; xferReg = 3'(rg); xferByte = 2'(by);
    xferLen = 4'(ln); xferWData = wd;
    @(negedge clk);
    xferEn = 1'b0; xferWrite = 1'b0; xferWData = '0;
  endtask

  task automatic setOps(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    opA = a; opB = b;
  endtask

  task automatic readWin(output logic [95:0] d);
    xfer(1'b0, 0, 0, 12, '0);
    d = rdData;
  endtask

  task automatic t_reset();
    logic [95:0] d;
    chk("R1 rdValid after reset", 96'(rdValid), 96'h0);
    chk("R1 xferErr after reset", 96'(xferErr), 96'h0);
    xfer(1'b0, 0, 0, 4, '0);
    chk("R1 control word after reset", rdData, 96'h0);
    chk("R1 read valid", 96'(rdValid), 96'h1);
    @(negedge clk);
    chk("R1 quiet after idle", {rdValid, xferErr}, 96'h0);
    d = '0;
  endtask

  task automatic t_mulOnly();
    logic [63:0] p;
    logic [31:0] av[3] = '{32'd3, 32'hFFFF_FFFF, 32'h1234_5678};
    logic [31:0] bv[3] = '{32'd5, 32'hFFFF_FFFF, 32'h9ABC_DEF0};
    for (int i = 0; i < 3; i++) begin
      setOps(av[i], bv[i]);
      p = 64'(av[i]) * 64'(bv[i]);
      xfer(1'b0, 1, 0, 8, '0);
      chk("R2 product pattern", rdData, {p, 32'h0});
    end
    // back-to-back: each read sees operands of the edge before
    setOps(32'd10, 32'd11);
    @(negedge clk);
    xferEn = 1'b1; xferWrite = 1'b0; xferReg = 3'd1; xferByte = 2'd0; xferLen = 4'd8;
    opA = 32'd20; opB = 32'd21;
    @(negedge clk);
    chk("R2 every cycle a", rdData, {64'd110, 32'h0});
    opA = 32'd30; opB = 32'd31;
    @(negedge clk);
    chk("R2 every cycle b", rdData, {64'd420, 32'h0});
    xferEn = 1'b0;
    @(negedge clk);
    chk("R2 every cycle c", 96'(rdValid), 96'h0);
  endtask

  task automatic t_accum();
    logic [95:0] d;
    logic [63:0] P, acc;
    logic [64:0] s;
    setOps(32'd7, 32'd6);
    xfer(1'b1, 0, 0, 1, 96'h1);
    readWin(d);
    chk("R3 first accumulate from zero", d, img(1'b1, 1'b0, 64'd42));
    setOps(32'd100, 32'd100);
    repeat (3) @(negedge clk);
    readWin(d);
    chk("R4 product holds", d, img(1'b1, 1'b0, 64'd42));
    xfer(1'b1, 0, 0, 4, 96'h1);
    readWin(d);
    chk("R4 accumulate", d, img(1'b1, 1'b0, 64'd10042));
    xfer(1'b1, 0, 0, 1, 96'h3);
    readWin(d);
    chk("R6 clear keeps product", d, img(1'b1, 1'b0, 64'd10042));
    setOps(32'd1, 32'd5);
    xfer(1'b1, 0, 0, 1, 96'h1);
    readWin(d);
    chk("R6 accumulator zeroed", d, img(1'b1, 1'b0, 64'd5));
    // drive a wrap
    P = 64'hFFFF_FFFF * 64'hFFFF_FFFF;
    setOps(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    xfer(1'b1, 0, 0, 1, 96'h1);
    acc = 64'd5 + P;
    readWin(d);
    chk("R5 no wrap yet", d, img(1'b1, 1'b0, acc));
    xfer(1'b1, 0, 0, 1, 96'h1);
    s = {1'b0, acc} + {1'b0, P};
    acc = s[63:0];
    readWin(d);
    chk("R5 wrap sets carry", d, img(1'b1, s[64], acc));
    // refused write that would clear must leave all state alone
    xfer(1'b1, 0, 0, 13, 96'h3);
    chk("R8 refused write flagged", {rdValid, xferErr}, 96'h1);
    readWin(d);
    chk("R8 state unchanged", d, img(1'b1, 1'b1, acc));
    setOps(32'd1, 32'd1);
    xfer(1'b1, 0, 0, 1, 96'h1);
    acc = acc + 64'd1;
    readWin(d);
    chk("R5 carry sticky", d, img(1'b1, 1'b1, acc));
    xfer(1'b1, 0, 0, 1, 96'h3);
    setOps(32'd2, 32'd3);
    xfer(1'b1, 0, 0, 1, 96'h1);
    readWin(d);
    chk("R6 carry and accumulator cleared", d, img(1'b1, 1'b0, 64'd6));
  endtask

  task automatic t_ignored();
    logic [95:0] d;
    xfer(1'b1, 1, 0, 8, {96{1'b1}});
    readWin(d);
    chk("R9 product write ignored", d, img(1'b1, 1'b0, 64'd6));
    xfer(1'b1, 0, 1, 3, {96{1'b1}});
    readWin(d);
    chk("R9 lanes 1..3 of control ignored", d, img(1'b1, 1'b0, 64'd6));
    // walk through lane 0 into product low: lane 0 acts, product lanes do not
    xfer(1'b1, 0, 0, 5, {{88{1'b1}}, 8'h01});
    readWin(d);
    chk("R7 walking write hits lane 0", d, img(1'b1, 1'b0, 64'd12));
  endtask

  task automatic t_lanes();
    logic [63:0] p;
    logic [95:0] im;
    xfer(1'b1, 0, 0, 1, 96'h0);
    setOps(32'hDEAD_BEEF, 32'h1234_5679);
    p = 64'hDEAD_BEEF * 64'h1234_5679;
    im = img(1'b0, 1'b0, p);
    @(negedge clk);
    xfer(1'b0, 0, 3, 3, '0);
    chk("R7 read across word boundary", rdData, im & laneMask(0, 3, 3));
    xfer(1'b0, 2, 2, 2, '0);
    chk("R7 read to window end", rdData, im & laneMask(2, 2, 2));
    chk("R7 end-of-window valid", {rdValid, xferErr}, 96'h2);
    xfer(1'b0, 1, 1, 0, '0);
    chk("R7 zero length", {rdValid, rdData}, {1'b1, 96'h0});
  endtask

  task automatic t_refuse();
    xfer(1'b0, 2, 1, 4, '0);
    chk("R8 read past end", {rdValid, xferErr, rdData}, {2'b01, 96'h0});
    xfer(1'b1, 3, 0, 1, 96'h1);
    chk("R8 write past end", {rdValid, xferErr}, 96'h1);
    @(negedge clk);
    chk("R8 error is a pulse", 96'(xferErr), 96'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mulOnly();
    t_accum();
    t_ignored();
    t_lanes();
    t_refuse();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule